// File: doc/BRIEF.md
# Bus Mastership Hand-off Controller

This block sits on the bus-owning side of a three-wire arbitration exchange: request, grant and grant-acknowledge. It watches an external request line, gives the bus away only between bus cycles and never while a locked read-modify-write sequence is under way, then waits for the other master to confirm it has taken over. Once that confirmation is withdrawn, the block takes the bus back and re-enables the drivers for address, data and control.

The two external lines are asynchronous. They pass through a two-stage synchronizer, so every hand-off edge lands in a fixed number of clock edges. With inputs changing mid-period, that gives the half-clock granularity of the timing windows. The lock flag and the cycle-in-progress flag come from logic inside the same clock domain and are used directly. The drive-enable output is low while grant is up and for as long as the other master holds the bus. It returns high a programmable number of clocks after the bus is reclaimed.

Top module: `bus_arb_handshake`

## Requirements
- R1: While reset is asserted, and right after it, grant is low and drive-enable is high. Reset also takes effect in the middle of a hand-off.
- R2: With the block idle, lock low and no cycle in progress, grant rises on the third rising clock edge after request is raised, which is 2.5 clocks when request changes at a falling edge.
- R3: No grant is issued while the lock flag is high. If request is still held when the lock flag clears, grant rises on the next rising edge.
- R4: No grant is issued while the cycle-in-progress flag is high. If request is still held when the flag clears, grant rises on the next rising edge.
- R5: Drive-enable falls on the same edge that grant rises, and is never high while grant is high.
- R6: After grant-acknowledge is raised, grant falls on the third rising edge (2.5 clocks), and drive-enable stays low.
- R7: While the other master holds grant-acknowledge, changes on request and on the lock flag have no effect: grant stays low and drive-enable stays low.
- R8: After grant-acknowledge falls, drive-enable returns high on the fourth rising edge: three edges of synchronizing and recognition, then RECLAIM_CLKS (default 1) clocks of turnaround.
- R9: If request is dropped while grant is up and no acknowledge has been seen, grant falls on the third rising edge after the drop, and drive-enable returns high RECLAIM_CLKS clocks after grant falls.
- R10: After the bus has been reclaimed, or after a reset, a new request is granted again with the R2 latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted in step with the clock |
| bus_req_i | input | 1 | External bus request, active high, asynchronous |
| grant_ack_i | input | 1 | External grant-acknowledge, active high, asynchronous |
| rmw_lock_i | input | 1 | Locked read-modify-write sequence in progress |
| cycle_busy_i | input | 1 | A bus cycle of this master is in progress |
| bus_grant_o | output | 1 | Bus grant to the external requester, active high |
| bus_drive_o | output | 1 | Enable for this master's address, data and control drivers |

## Verification
The bench counts clock edges across each hand-off edge. A design with one synchronizer stage too many or too few moves grant or drive-enable by a clock and fails the window checks. Request is held across a lock period and across a busy cycle: a design that tests only the synchronized request would grant in the middle of an indivisible transfer. Request is dropped and the lock flag raised while acknowledge is still held, which catches a design that reclaims the bus early or grants again. Grant is also withdrawn without any acknowledge, and reset is applied mid-grant, to show the bus comes back in both cases instead of hanging.

// File: rtl/bah_pkg.sv
package bah_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_GRANTED = 2'd1,
    ST_HELD    = 2'd2,
    ST_RECLAIM = 2'd3
  } arb_state_e;

endpackage

// File: rtl/bah_sync.sv
module bah_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  // shift chain, one stage per clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_chk
      AST_SYNC_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stg_q[g] == $past(stg_q[g-1])); // R2
    end
  endgenerate

endmodule

// File: rtl/bah_timer.sv
module bah_timer #(
  parameter int LIMIT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done_o = run_i && (cnt_q == LAST);
  assign cnt_en = !run_i || !done_o;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (!done_o) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_TIMER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R8

  AST_TIMER_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/bah_fsm.sv
module bah_fsm
  import bah_pkg::*;
#(
  parameter int RECLAIM_CLKS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_s_i,
  input  logic ack_s_i,
  input  logic lock_i,
  input  logic busy_i,
  output logic grant_o,
  output logic drive_o
);

  arb_state_e state_q, state_d;
  logic       st_en;
  logic       tmr_run, tmr_done;
  logic       grant_q, drive_q;

  assign tmr_run = (state_q == ST_RECLAIM);

  bah_timer #(
    .LIMIT (RECLAIM_CLKS)
  ) u_reclaim_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (tmr_run),
    .done_o (tmr_done)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_s_i && !lock_i && !busy_i) state_d = ST_GRANTED;
      end
      ST_GRANTED: begin
        if (ack_s_i)       state_d = ST_HELD;
        else if (!req_s_i) state_d = ST_RECLAIM;
      end
      ST_HELD: begin
        if (!ack_s_i) state_d = ST_RECLAIM;
      end
      ST_RECLAIM: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign st_en = (state_d != state_q);

  // registers, outputs decoded from the next state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      grant_q <= 1'b0;
      drive_q <= 1'b1;
    end else if (st_en) begin
      state_q <= state_d;
      grant_q <= (state_d == ST_GRANTED);
      drive_q <= (state_d == ST_IDLE);
    end
  end

  assign grant_o = grant_q;
  assign drive_o = drive_q;

  AST_NO_GRANT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_q) |-> !$past(lock_i)); // R3

  AST_NO_GRANT_MID_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_q) |-> !$past(busy_i)); // R4

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_q) |-> $past(req_s_i)); // R2

  AST_GRANT_DROPS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_q) |-> $fell(drive_q)); // R5

  AST_HOLD_WHILE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD && ack_s_i) |=> (state_q == ST_HELD && !grant_q && !drive_q)); // R7

  AST_ACK_DROPS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GRANTED && ack_s_i) |=> !grant_q); // R6

  AST_WITHDRAW_DROPS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GRANTED && !ack_s_i && !req_s_i) |=> !grant_q); // R9

  AST_DRIVE_AFTER_RECLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_q) |-> $past(tmr_done)); // R8

endmodule

// File: rtl/bus_arb_handshake.sv
module bus_arb_handshake #(
  parameter int SYNC_STAGES  = 2,
  parameter int RECLAIM_CLKS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_req_i,
  input  logic grant_ack_i,
  input  logic rmw_lock_i,
  input  logic cycle_busy_i,
  output logic bus_grant_o,
  output logic bus_drive_o
);

  localparam int EXT_W = 2;

  logic [EXT_W-1:0] ext_raw, ext_sync;

  assign ext_raw = {grant_ack_i, bus_req_i};

  bah_sync #(
    .W      (EXT_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ext_raw),
    .q_o    (ext_sync)
  );

  bah_fsm #(
    .RECLAIM_CLKS (RECLAIM_CLKS)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_s_i (ext_sync[0]),
    .ack_s_i (ext_sync[1]),
    .lock_i  (rmw_lock_i),
    .busy_i  (cycle_busy_i),
    .grant_o (bus_grant_o),
    .drive_o (bus_drive_o)
  );

  AST_GRANT_DRIVE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_grant_o |-> !bus_drive_o); // R5

endmodule

// File: tb/bus_arb_handshake_tb_top.sv
module bus_arb_handshake_tb_top;

  logic clk, rst_n;
  logic req, ack, lock, busy;
  logic grant, drive;
  int   n_chk, n_err;
  bit   done;

  bus_arb_handshake dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bus_req_i    (req),
    .grant_ack_i  (ack),
    .rmw_lock_i   (lock),
    .cycle_busy_i (busy),
    .bus_grant_o  (grant),
    .bus_drive_o  (drive)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {req, ack, lock, busy, expected grant, expected drive}
  // inputs applied right after the row's check at a falling edge
  localparam int NROWS = 45;
  localparam logic [5:0] VEC [NROWS] = '{
    6'b000001, 6'b100001, 6'b100001, 6'b100001, 6'b100010,
    6'b110010, 6'b110010, 6'b110010, 6'b010000, 6'b010000,
    6'b010000, 6'b000000, 6'b000000, 6'b000000, 6'b000000,
    6'b000001, 6'b101001, 6'b101001, 6'b101001, 6'b101001,
    6'b101001, 6'b100001, 6'b100010, 6'b000010, 6'b000010,
    6'b000010, 6'b000000, 6'b000001, 6'b100101, 6'b100101,
    6'b100101, 6'b100101, 6'b100001, 6'b100010, 6'b110010,
    6'b010010, 6'b010010, 6'b011000, 6'b011000, 6'b001000,
    6'b001000, 6'b001000, 6'b001000, 6'b000001, 6'b000001
  };

  function automatic string row_tag(int r);
    if (r <= 4)  return "R2";
    if (r <= 8)  return "R6";
    if (r <= 15) return "R8";
    if (r <= 22) return "R3";
    if (r <= 27) return "R9";
    if (r <= 33) return "R4";
    if (r <= 38) return "R7";
    return "R8";
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; req = 1'b0; ack = 1'b0; lock = 1'b0; busy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "grant in reset", grant, 1'b0);
    chk("R1", "drive in reset", drive, 1'b1);
    rst_n = 1'b1;

    for (int r = 0; r < NROWS; r++) begin
      @(negedge clk);
      chk(row_tag(r), $sformatf("row %0d grant", r), grant, VEC[r][1]);
      chk(row_tag(r), $sformatf("row %0d drive", r), drive, VEC[r][0]);
      if (grant && drive) chk("R5", "grant with drive", drive, 1'b0);
      {req, ack, lock, busy} = VEC[r][5:2];
    end

    // re-grant after the bus was reclaimed
    @(negedge clk);
    req = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "grant early", grant, 1'b0);
    @(negedge clk);
    chk("R10", "re-grant", grant, 1'b1);
    chk("R5", "drive during re-grant", drive, 1'b0);

    // reset in the middle of a grant
    rst_n = 1'b0;
    #1;
    chk("R1", "grant after mid reset", grant, 1'b0);
    chk("R1", "drive after mid reset", drive, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "grant early after reset", grant, 1'b0);
    @(negedge clk);
    chk("R10", "grant after reset", grant, 1'b1);

    // withdraw with no acknowledge
    req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "grant held in window", grant, 1'b1);
    @(negedge clk);
    chk("R9", "grant withdrawn", grant, 1'b0);
    chk("R9", "drive still off", drive, 1'b0);
    @(negedge clk);
    chk("R9", "drive restored", drive, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule